// File: doc/BRIEF.md
# Add-with-Carry Indirect Execution Unit

This unit executes the eight-opcode family of add-with-carry instructions for a small 4-bit accumulator core. Each instruction takes a nibble from data memory and adds it, together with the carry flag, into accumulator A or B. The memory location comes from index register X or Y. Some forms step the chosen index by one after the access.

A one-byte extension prefix can go ahead of an instruction. The prefix raises the extension flag E and stores its byte. If the next instruction is a plain X form, the operand is read from page 0x00 at that byte. If it is a plain Y form, the operand is read from page 0xFF at that byte. Post-increment forms ignore a pending prefix.

The memory read port is combinational. `mem_addr` is derived from the opcode and the current state, and `mem_rdata` must return the nibble in the same cycle. All architectural state changes at the clock edge where `op_valid` is high.

Top module: `adc_ind_unit`

## Requirements
- R1: Legal opcodes are 0x19E0 to 0x19E7. Opcode bit 2 picks the destination (0 = A, 1 = B). Bit 1 picks the index (0 = X, 1 = Y). Bit 0 set means post-increment.
- R2: At the edge where `op_valid` is high with a legal opcode, the destination becomes (destination + `mem_rdata` + C) mod 16. In the following cycle `done` is high for exactly one cycle per instruction.
- R3: The same edge sets C to the carry out of bit 3 of that sum. It sets Z to 1 when the 4-bit result is zero, else 0.
- R4: Every legal instruction leaves E cleared.
- R5: When `pfx_valid` is high and `op_valid` is low, the edge sets E and stores `pfx_imm`. A prefix presented in the same cycle as an instruction is ignored.
- R6: With E set, the X form without increment reads address 0x0000 + imm and the Y form without increment reads 0xFF00 + imm. The index register is not changed.
- R7: Post-increment forms read at the plain index even when E is set. After the access the index gains 1, wrapping from 0xFFFF to 0x0000.
- R8: The index increment never alters C, Z or E beyond what R3 and R4 define, including on the wrap from 0xFFFF.
- R9: An opcode outside 0x19E0 to 0x19E7 with `op_valid` high gives a one-cycle `illegal` pulse and no `done`. It changes no accumulator, index, flag or stored prefix byte, and a pending E survives it.
- R10: After reset, accumulators, indices, flags, `done` and `illegal` are all zero.
- R11: Without a pending prefix, `mem_addr` equals the index register selected by opcode bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 13 | Instruction opcode |
| pfx_valid | input | 1 | Extension prefix present this cycle |
| pfx_imm | input | 8 | Prefix byte |
| mem_addr | output | 16 | Data-memory read address |
| mem_rdata | input | 4 | Data-memory read nibble (same cycle) |
| acc_a | output | 4 | Accumulator A |
| acc_b | output | 4 | Accumulator B |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |
| flag_e | output | 1 | Extension flag |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| done | output | 1 | Instruction completed pulse |
| illegal | output | 1 | Illegal opcode pulse |

## Verification
All eight opcodes run against an address-hashed memory image, so a wrong address, a wrong destination or a lost carry changes the accumulators. A long run of X post-increments carries X through 0xFFFF. Along the way the flags are compared at every step, which separates the index increment from the carry logic. Prefixes are paired with each opcode form, presented together with an instruction, and left pending across an illegal opcode. These cases separate paged addressing, refusal of the prefix on post-increment forms, and E clearing.

// File: rtl/adc_pkg.sv
package adc_pkg;
   typedef enum logic {DST_A = 1'b0, DST_B = 1'b1} dst_e;

   typedef struct packed {
      logic legal;
      dst_e dst;
      logic use_y;
      logic post_inc;
   } adc_op_t;
endpackage

// File: rtl/adc_op_decode.sv
module adc_op_decode
   import adc_pkg::*;
#(
   parameter int unsigned OP_W    = 13,
   parameter logic [OP_W-1:0] OP_BASE = 13'h19E0
) (
   input  logic [OP_W-1:0] op_code,
   output adc_op_t         op
);
   localparam int unsigned FIELD_W = 3;
   localparam logic [OP_W-1:FIELD_W] FAMILY = OP_BASE[OP_W-1:FIELD_W];

   if (OP_BASE[FIELD_W-1:0] != '0) begin : g_bad_base
      $error("OP_BASE must be aligned to an eight-opcode group");
   end

   always_comb begin
      op.legal    = (op_code[OP_W-1:FIELD_W] == FAMILY);
      op.dst      = dst_e'(op_code[2]);
      op.use_y    = op_code[1];
      op.post_inc = op_code[0];
   end
endmodule

// File: rtl/adc_ea_gen.sv
module adc_ea_gen #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned PAGE_W = 8,
   parameter bit          EXT_EN = 1'b1
) (
   input  logic              use_y,
   input  logic              post_inc,
   input  logic              ext_pend,
   input  logic [PAGE_W-1:0] imm,
   input  logic [ADDR_W-1:0] idx_x,
   input  logic [ADDR_W-1:0] idx_y,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned HI_W = ADDR_W - PAGE_W;
   localparam logic [HI_W-1:0] LOW_PAGE  = '0;
   localparam logic [HI_W-1:0] HIGH_PAGE = '1;

   logic [ADDR_W-1:0] plain;
   assign plain = use_y ? idx_y : idx_x;

   if (EXT_EN) begin : g_paged
      logic use_ext;
      assign use_ext = ext_pend & ~post_inc;
      always_comb begin
         if (use_ext) addr = {(use_y ? HIGH_PAGE : LOW_PAGE), imm};
         else         addr = plain;
      end
   end else begin : g_flat
      logic unused_ok;
      assign unused_ok = ext_pend ^ post_inc ^ (^imm);
      assign addr = plain;
   end
endmodule

// File: rtl/adc_addc.sv
module adc_addc #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         zero
);
   logic [W:0] cy;
   assign cy[0] = cin;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i]  = a[i] ^ b[i] ^ cy[i];
      assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
   end

   assign cout = cy[W];
   assign zero = (sum == '0);
endmodule

// File: rtl/adc_ind_unit.sv
module adc_ind_unit
   import adc_pkg::*;
#(
   parameter int unsigned DATA_W  = 4,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned PAGE_W  = 8,
   parameter int unsigned OP_W    = 13,
   parameter logic [OP_W-1:0] OP_BASE = 13'h19E0,
   parameter bit          EXT_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [OP_W-1:0]   op_code,
   input  logic              pfx_valid,
   input  logic [PAGE_W-1:0] pfx_imm,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] acc_a,
   output logic [DATA_W-1:0] acc_b,
   output logic [ADDR_W-1:0] idx_x,
   output logic [ADDR_W-1:0] idx_y,
   output logic              flag_e,
   output logic              flag_c,
   output logic              flag_z,
   output logic              done,
   output logic              illegal
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   if (PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must be narrower than ADDR_W");
   end
   if (OP_W < 4) begin : g_bad_op
      $error("OP_W too small for the opcode fields");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   adc_op_t           op;
   logic [PAGE_W-1:0] imm_q;
   logic [DATA_W-1:0] src, sum;
   logic              cout, zero, exec;

   adc_op_decode #(.OP_W(OP_W), .OP_BASE(OP_BASE)) u_dec (
      .op_code (op_code),
      .op      (op)
   );

   adc_ea_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .EXT_EN(EXT_EN)) u_ea (
      .use_y    (op.use_y),
      .post_inc (op.post_inc),
      .ext_pend (flag_e),
      .imm      (imm_q),
      .idx_x    (idx_x),
      .idx_y    (idx_y),
      .addr     (mem_addr)
   );

   assign src = (op.dst == DST_B) ? acc_b : acc_a;

   adc_addc #(.W(DATA_W)) u_add (
      .a    (src),
      .b    (mem_rdata),
      .cin  (flag_c),
      .sum  (sum),
      .cout (cout),
      .zero (zero)
   );

   assign exec = op_valid & op.legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_a   <= '0;
         acc_b   <= '0;
         idx_x   <= '0;
         idx_y   <= '0;
         imm_q   <= '0;
         flag_e  <= 1'b0;
         flag_c  <= 1'b0;
         flag_z  <= 1'b0;
         done    <= 1'b0;
         illegal <= 1'b0;
      end else begin
         done    <= exec;
         illegal <= op_valid & ~op.legal;
         if (exec) begin
            if (op.dst == DST_B) acc_b <= sum;
            else                 acc_a <= sum;
            flag_c <= cout;
            flag_z <= zero;
            flag_e <= 1'b0;
            if (op.post_inc) begin
               if (op.use_y) idx_y <= idx_y + ONE;
               else          idx_x <= idx_x + ONE;
            end
         end else if (pfx_valid && !op_valid) begin
            flag_e <= 1'b1;
            imm_q  <= pfx_imm;
         end
      end
   end
endmodule

// File: rtl/adc_ind_unit_chk.sv
module adc_ind_unit_chk #(
   parameter int unsigned DATA_W  = 4,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned PAGE_W  = 8,
   parameter int unsigned OP_W    = 13,
   parameter logic [OP_W-1:0] OP_BASE = 13'h19E0,
   parameter bit          EXT_EN  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [OP_W-1:0]   op_code,
   input logic              pfx_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] acc_a,
   input logic [DATA_W-1:0] acc_b,
   input logic [ADDR_W-1:0] idx_x,
   input logic [ADDR_W-1:0] idx_y,
   input logic              flag_e,
   input logic              flag_c,
   input logic              flag_z,
   input logic              done,
   input logic              illegal
);
   localparam logic [OP_W-1:3] FAMILY = OP_BASE[OP_W-1:3];
   localparam int unsigned HI_W = ADDR_W - PAGE_W;

   logic fam;
   assign fam = (op_code[OP_W-1:3] == FAMILY);

   a_r2_done_after_op: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(op_valid));

   a_r9_done_xor_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && illegal));

   a_r9_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> ($stable(acc_a) && $stable(acc_b) && $stable(idx_x) && $stable(idx_y)
                   && $stable(flag_c) && $stable(flag_z) && $stable(flag_e)));

   a_r4_e_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !flag_e);

   a_r5_prefix_sets_e: assert property (@(posedge clk) disable iff (!rst_n)
      (pfx_valid && !op_valid) |=> (flag_e && !done));

   a_r3_zero_on_a: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && fam && !op_code[2]) |=> (flag_z == (acc_a == '0)));

   a_r7_postinc_x: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && fam && op_code[1:0] == 2'b01) |=> (idx_x == $past(idx_x) + ADDR_W'(1)));

   a_r6_high_page_y: assert property (@(posedge clk) disable iff (!rst_n)
      (EXT_EN && op_valid && fam && op_code[1:0] == 2'b10 && flag_e)
         |-> (mem_addr[ADDR_W-1:PAGE_W] == {HI_W{1'b1}}));
endmodule

bind adc_ind_unit adc_ind_unit_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
   .OP_W(OP_W), .OP_BASE(OP_BASE), .EXT_EN(EXT_EN)
) u_chk (.*);

// File: tb/adc_ind_unit_test.sv
module adc_ind_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [12:0] op_code = '0;
   logic        pfx_valid = 1'b0;
   logic [7:0]  pfx_imm = '0;
   logic [15:0] mem_addr;
   logic [3:0]  mem_rdata;
   logic [3:0]  acc_a, acc_b;
   logic [15:0] idx_x, idx_y;
   logic        flag_e, flag_c, flag_z, done, illegal;

   int n_checks = 0;
   int n_fail   = 0;

   // reference state
   int m_a, m_b, m_x, m_y, m_imm, m_e, m_c, m_z, m_done, m_ill;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [3:0] mem_f(input logic [15:0] ad);
      return 4'((ad[3:0] * 3) + ad[7:4] + (ad[11:8] * 5) + ad[15:12] + 7);
   endfunction

   assign mem_rdata = mem_f(mem_addr);

   adc_ind_unit uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .pfx_valid(pfx_valid), .pfx_imm(pfx_imm), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .acc_a(acc_a), .acc_b(acc_b), .idx_x(idx_x),
      .idx_y(idx_y), .flag_e(flag_e), .flag_c(flag_c), .flag_z(flag_z),
      .done(done), .illegal(illegal)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      int got, want;
      got  = {acc_a, acc_b, idx_x, idx_y, flag_e, flag_c, flag_z, done, illegal};
      want = 0;
      n_checks++;
      if (acc_a !== 4'(m_a) || acc_b !== 4'(m_b) || idx_x !== 16'(m_x) || idx_y !== 16'(m_y)
          || flag_e !== 1'(m_e) || flag_c !== 1'(m_c) || flag_z !== 1'(m_z)
          || done !== 1'(m_done) || illegal !== 1'(m_ill)) begin
         n_fail++;
         $display("FAIL %s state: actual a=%0h b=%0h x=%0h y=%0h e%0d c%0d z%0d done%0d ill%0d expected a=%0h b=%0h x=%0h y=%0h e%0d c%0d z%0d done%0d ill%0d",
                  tag, acc_a, acc_b, idx_x, idx_y, flag_e, flag_c, flag_z, done, illegal,
                  m_a, m_b, m_x, m_y, m_e, m_c, m_z, m_done, m_ill);
      end
      if (got == want) got = 0;
   endtask

   // one cycle: drive at a falling edge, check address, advance model, check state
   task automatic step(input logic ov, input logic [12:0] oc, input logic pv,
                       input logic [7:0] pi, input string tag);
      int legal, dst, iy, pinc, addr, d, s, src;
      op_valid = ov; op_code = oc; pfx_valid = pv; pfx_imm = pi;
      #1;
      legal = (oc[12:3] == 10'h33C);
      dst = oc[2]; iy = oc[1]; pinc = oc[0];
      if (m_e != 0 && pinc == 0) addr = iy ? (16'hFF00 | m_imm) : m_imm;
      else                       addr = iy ? m_y : m_x;
      if (ov && legal) chk(tag, "mem_addr", mem_addr, addr);
      m_done = 0; m_ill = 0;
      if (ov) begin
         if (legal) begin
            d   = mem_f(16'(addr));
            src = dst ? m_b : m_a;
            s   = src + d + m_c;
            if (dst) m_b = s & 15; else m_a = s & 15;
            m_c = (s >> 4) & 1;
            m_z = ((s & 15) == 0);
            m_e = 0;
            if (pinc) begin
               if (iy) m_y = (m_y + 1) & 16'hFFFF;
               else    m_x = (m_x + 1) & 16'hFFFF;
            end
            m_done = 1;
         end else m_ill = 1;
      end else if (pv) begin
         m_e = 1; m_imm = pi;
      end
      @(negedge clk);
      op_valid = 1'b0; pfx_valid = 1'b0;
      compare_all(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int zeros;
      m_a = 0; m_b = 0; m_x = 0; m_y = 0; m_imm = 0; m_e = 0; m_c = 0; m_z = 0;
      m_done = 0; m_ill = 0;
      repeat (3) @(negedge clk);
      compare_all("R10 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R10 idle");

      // R1 R2 R11: all four plain forms and all four increment forms
      for (int k = 0; k < 8; k++) step(1'b1, 13'h19E0 + 13'(k), 1'b0, 8'h00, "R1 R2 R11 form");
      for (int k = 0; k < 8; k++) step(1'b1, 13'h19E7 - 13'(k), 1'b0, 8'h00, "R2 R3 form");
      // R2: back-to-back ops keep done high each cycle, then idle drops it
      step(1'b0, 13'h0, 1'b0, 8'h00, "R2 idle after burst");

      // R5 R6: prefix then X form, prefix then Y form
      step(1'b0, 13'h0, 1'b1, 8'h3C, "R5 prefix");
      step(1'b1, 13'h19E0, 1'b0, 8'h00, "R6 low page X");
      step(1'b0, 13'h0, 1'b1, 8'hA5, "R5 prefix");
      step(1'b1, 13'h19E6, 1'b0, 8'h00, "R6 high page Y");
      step(1'b0, 13'h0, 1'b1, 8'h11, "R5 prefix");
      step(1'b1, 13'h19E4, 1'b0, 8'h00, "R6 low page X into B");
      step(1'b1, 13'h19E2, 1'b0, 8'h00, "R4 R11 E cleared");

      // R7: prefix refused by increment forms
      step(1'b0, 13'h0, 1'b1, 8'h77, "R5 prefix");
      step(1'b1, 13'h19E3, 1'b0, 8'h00, "R7 prefix ignored Y+");
      step(1'b0, 13'h0, 1'b1, 8'h78, "R5 prefix");
      step(1'b1, 13'h19E5, 1'b0, 8'h00, "R7 prefix ignored X+");

      // R5: prefix together with an instruction is dropped
      step(1'b1, 13'h19E0, 1'b1, 8'hEE, "R5 simultaneous prefix");
      step(1'b1, 13'h19E0, 1'b0, 8'h00, "R5 no pending E");

      // R9: illegal opcodes, E survives
      step(1'b1, 13'h19DF, 1'b0, 8'h00, "R9 below range");
      step(1'b1, 13'h19E8, 1'b0, 8'h00, "R9 above range");
      step(1'b0, 13'h0, 1'b1, 8'h42, "R5 prefix");
      step(1'b1, 13'h0000, 1'b0, 8'h00, "R9 E kept");
      step(1'b1, 13'h19E2, 1'b0, 8'h00, "R9 R6 E used after illegal");

      // R7 R8 R3: walk X through the wrap with flags checked each step
      zeros = 0;
      for (int k = 0; k < 65540; k++) begin
         step(1'b1, (k % 2 == 0) ? 13'h19E1 : 13'h19E5, 1'b0, 8'h00, "R7 R8 walk");
         if (m_z != 0) zeros++;
      end
      chk("R3", "zero results seen", (zeros > 0), 1);
      chk("R7", "idx_x after wrap", idx_x, m_x);
      step(1'b1, 13'h19E3, 1'b0, 8'h00, "R8 Y+ flags");

      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule